// File: doc/BRIEF.md
# Trigger Class Stage Scalers

This block is a bank of event counters that tracks trigger activity. Each trigger input has a counter that advances on every cycle in which the input is active. Each trigger class has six counters, one for each of three decision levels on each side of the busy and pile-up veto. One counts the class candidates seen before the veto. The other counts the ones that survived it.

All counters run continuously. A snapshot strobe copies every count into a shadow bank in a single cycle, so ratios between levels, or between the two sides of the veto, all refer to the same instant. Software reads only the shadow bank, through a small address/strobe read port that returns data on the next cycle. A clear strobe restarts every live count and overflow flag at once. Counters stop at their largest value and never wrap.

Top module: `trig_scalers`

## Requirements
- R1: After reset, every address reads back a count of zero with its overflow flag low, and `rd_data_o` and `rd_ovf_o` are zero.
- R2: The live counter of trigger input k increases by one on each clock edge at which `in_act_i[k]` is high.
- R3: For class c and level l (l = 0, 1, 2), the before-veto counter increases by one on each edge at which `cls_pre_i[3*c+l]` is high.
- R4: The after-veto counter of class c, level l increases only on an edge where `cls_post_i[3*c+l]` and `cls_pre_i[3*c+l]` are both high. A surviving bit without its candidate bit is ignored. An after-veto count therefore never exceeds the matching before-veto count.
- R5: A counter that holds all-ones keeps that value when it receives another increment, and that increment sets the counter's overflow flag. The flag stays set until a clear.
- R6: On an edge with `snap_i` high, the shadow bank takes every live count and flag as it stood before that edge's increments. Reads return shadow values only, so live activity stays invisible until the next snapshot.
- R7: On an edge with `clr_i` high, every live count and flag becomes zero, even if an increment arrives on the same edge. The shadow bank is not affected. A snapshot on the same edge captures the values from before the clear.
- R8: Address map: input k is at address k. For class c, level l, the before-veto counter is at N_IN + 6c + 2l and the after-veto counter is at N_IN + 6c + 2l + 1.
- R9: A read issued with `rd_en_i` high on one edge presents the shadow count and flag of `rd_addr_i` on `rd_data_o`/`rd_ovf_o` after that edge. Addresses at or above the counter total return zero with the flag low. The outputs hold their value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_act_i | input | N_IN | Trigger input activity, one bit per input |
| cls_pre_i | input | 3*N_CLS | Class candidate per level, before veto (bit 3c+l) |
| cls_post_i | input | 3*N_CLS | Class survivor per level, after veto (bit 3c+l) |
| snap_i | input | 1 | Copy all live counters into the shadow bank |
| clr_i | input | 1 | Zero all live counters and overflow flags |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W | Read address (map in R8) |
| rd_data_o | output | CNT_W | Shadow count returned one cycle after the strobe |
| rd_ovf_o | output | 1 | Overflow flag of the counter that was read |

## Verification
The bench builds the block with N_IN=3, N_CLS=2, CNT_W=6 and ADDR_W=5. This gives 15 counters and leaves addresses 15 to 31 free for out-of-range reads. Six-bit counters reach all-ones within about seventy cycles, so saturation and the overflow flag can be tested together with the clear-over-increment and snapshot-during-clear orderings. A behavioural model that holds live and shadow values in integer arrays predicts the read port on every clock. Every scan of the address map also checks that no after-veto count exceeds its before-veto partner.

// File: rtl/scaler_pkg.sv
package scaler_pkg;
    localparam int LEVELS = 3;
    localparam int SIDES  = 2;

    // Address slot of a class counter: inputs first, then per class,
    // per level, before-veto then after-veto.
    function automatic int cls_slot(input int n_in, input int c,
                                    input int l, input int post);
        return n_in + (c * LEVELS + l) * SIDES + post;
    endfunction
endpackage

// File: rtl/scl_counter.sv
module scl_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (inc_i) begin
            if (&st_q.cnt) st_d.ovf = 1'b1;
            else           st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/scl_shadow_read.sv
module scl_shadow_read #(
    parameter int NT = 16,
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NT-1:0][W-1:0] live_cnt_i,
    input  logic [NT-1:0]        live_ovf_i,
    input  logic                 snap_i,
    input  logic                 rd_en_i,
    input  logic [AW-1:0]        rd_addr_i,
    output logic [W-1:0]         rd_data_o,
    output logic                 rd_ovf_o
);
    localparam int IW = (NT > 1) ? $clog2(NT) : 1;

    typedef struct packed {
        logic [NT-1:0][W-1:0] sh_cnt;
        logic [NT-1:0]        sh_ovf;
        logic [W-1:0]         rd_data;
        logic                 rd_ovf;
    } shd_st_t;

    shd_st_t s_d, s_q;
    logic [IW-1:0] idx;
    logic          in_range;

    assign in_range = (int'(rd_addr_i) < NT);
    assign idx      = in_range ? IW'(rd_addr_i) : '0;

    always_comb begin
        s_d = s_q;
        if (snap_i) begin
            s_d.sh_cnt = live_cnt_i;
            s_d.sh_ovf = live_ovf_i;
        end
        if (rd_en_i) begin
            s_d.rd_data = in_range ? s_q.sh_cnt[idx] : '0;
            s_d.rd_ovf  = in_range ? s_q.sh_ovf[idx] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data_o = s_q.rd_data;
    assign rd_ovf_o  = s_q.rd_ovf;
endmodule

// File: rtl/trig_scalers.sv
module trig_scalers #(
    parameter int N_IN   = 50,
    parameter int N_CLS  = 50,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 9
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_IN-1:0]                 in_act_i,
    input  logic [scaler_pkg::LEVELS*N_CLS-1:0] cls_pre_i,
    input  logic [scaler_pkg::LEVELS*N_CLS-1:0] cls_post_i,
    input  logic                            snap_i,
    input  logic                            clr_i,
    input  logic                            rd_en_i,
    input  logic [ADDR_W-1:0]               rd_addr_i,
    output logic [CNT_W-1:0]                rd_data_o,
    output logic                            rd_ovf_o
);
    import scaler_pkg::*;

    localparam int N_TOT = N_IN + N_CLS * LEVELS * SIDES;

    logic [N_TOT-1:0]            inc;
    logic [N_TOT-1:0][CNT_W-1:0] live_cnt;
    logic [N_TOT-1:0]            live_ovf;

    // Increment sources: input activity, then class stages.
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign inc[i] = in_act_i[i];
    end

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
            localparam int BIT  = c * LEVELS + l;
            localparam int PRE  = cls_slot(N_IN, c, l, 0);
            localparam int POST = cls_slot(N_IN, c, l, 1);
            assign inc[PRE]  = cls_pre_i[BIT];
            // a survivor is only counted together with its candidate
            assign inc[POST] = cls_pre_i[BIT] & cls_post_i[BIT];
        end
    end

    for (genvar k = 0; k < N_TOT; k++) begin : g_cnt
        scl_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_i),
            .inc_i (inc[k]),
            .cnt_o (live_cnt[k]),
            .ovf_o (live_ovf[k])
        );
    end

    scl_shadow_read #(.NT(N_TOT), .W(CNT_W), .AW(ADDR_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .live_cnt_i (live_cnt),
        .live_ovf_i (live_ovf),
        .snap_i     (snap_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .rd_data_o  (rd_data_o),
        .rd_ovf_o   (rd_ovf_o)
    );
endmodule

// File: rtl/scl_chk.sv
module scl_chk #(
    parameter int N_IN  = 50,
    parameter int N_CLS = 50,
    parameter int CNT_W = 32,
    parameter int N_TOT = 350
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            clr_i,
    input logic                            rd_en_i,
    input logic [CNT_W-1:0]                rd_data_o,
    input logic                            rd_ovf_o,
    input logic [N_TOT-1:0][CNT_W-1:0]     live_cnt,
    input logic [N_TOT-1:0]                live_ovf
);
    import scaler_pkg::*;

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (live_cnt == '0) && (live_ovf == '0));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en_i) |-> ($stable(rd_data_o) && $stable(rd_ovf_o)));

    for (genvar k = 0; k < N_TOT; k++) begin : g_k
        // R5
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (&live_cnt[k] && !clr_i) |=> &live_cnt[k]);
        // R5
        ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(live_ovf[k]) |-> $past(&live_cnt[k]));
        // R2
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(clr_i) |->
                (CNT_W'(live_cnt[k] - $past(live_cnt[k])) <= CNT_W'(1)));
    end

    for (genvar c = 0; c < N_CLS; c++) begin : g_c
        for (genvar l = 0; l < LEVELS; l++) begin : g_l
            // R4
            post_le_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
                live_cnt[cls_slot(N_IN, c, l, 1)] <= live_cnt[cls_slot(N_IN, c, l, 0)]);
        end
    end
endmodule

bind trig_scalers scl_chk #(
    .N_IN(N_IN), .N_CLS(N_CLS), .CNT_W(CNT_W), .N_TOT(N_TOT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .rd_en_i   (rd_en_i),
    .rd_data_o (rd_data_o),
    .rd_ovf_o  (rd_ovf_o),
    .live_cnt  (live_cnt),
    .live_ovf  (live_ovf)
);

// File: tb/test_trig_scalers.sv
module test_trig_scalers;
    localparam int NI = 3;
    localparam int NC = 2;
    localparam int W  = 6;
    localparam int AW = 5;
    localparam int NT = NI + NC * 6;
    localparam int MAXV = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NI-1:0]   in_act = '0;
    logic [3*NC-1:0] pre = '0, post = '0;
    logic snap = 1'b0, clr = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0] rd_data;
    logic rd_ovf;

    always #2 clk = ~clk;

    trig_scalers #(.N_IN(NI), .N_CLS(NC), .CNT_W(W), .ADDR_W(AW)) i_trig_scalers (
        .clk(clk), .rst_n(rst_n), .in_act_i(in_act), .cls_pre_i(pre),
        .cls_post_i(post), .snap_i(snap), .clr_i(clr), .rd_en_i(rd_en),
        .rd_addr_i(addr), .rd_data_o(rd_data), .rd_ovf_o(rd_ovf));

    int live [NT];
    int sh [NT];
    bit lovf [NT];
    bit shovf [NT];
    int exp_d = 0;
    bit exp_o = 1'b0;
    int exp_a = -1;
    int got [NT];
    int checks = 0, errors = 0;
    string tag = "R1";
    bit done = 1'b0;

    // expected increment of counter k, from R2, R3, R4, R8
    function automatic bit inc_of(int k);
        int j, c, l;
        if (k < NI) return in_act[k];
        j = k - NI; c = j / 6; l = (j / 2) % 3;
        if (j % 2 == 0) return pre[3*c+l];
        return pre[3*c+l] & post[3*c+l];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NT; k++) begin
                live[k] = 0; sh[k] = 0; lovf[k] = 0; shovf[k] = 0;
            end
            exp_d = 0; exp_o = 0; exp_a = -1;
        end else begin
            bit incs [NT];
            for (int k = 0; k < NT; k++) incs[k] = inc_of(k);
            if (rd_en) begin
                exp_a = int'(addr);
                exp_d = (exp_a < NT) ? sh[exp_a] : 0;
                exp_o = (exp_a < NT) ? shovf[exp_a] : 1'b0;
            end
            if (snap) for (int k = 0; k < NT; k++) begin
                sh[k] = live[k]; shovf[k] = lovf[k];
            end
            for (int k = 0; k < NT; k++) begin
                if (clr) begin live[k] = 0; lovf[k] = 0; end
                else if (incs[k]) begin
                    if (live[k] == MAXV) lovf[k] = 1;
                    else live[k] = live[k] + 1;
                end
            end
        end
    end

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        checks++;
        if (int'(rd_data) != exp_d || rd_ovf != exp_o) begin
            errors++;
            $display("FAIL %s addr=%0d data=%0d ovf=%0d expected data=%0d ovf=%0d",
                     tag, exp_a, rd_data, rd_ovf, exp_d, exp_o);
        end
        if (exp_a >= 0 && exp_a < NT) got[exp_a] = int'(rd_data);
    end

    task automatic step(input logic [NI-1:0] a, input logic [3*NC-1:0] p,
                        input logic [3*NC-1:0] q, input bit s, input bit c,
                        input bit r, input int ad);
        in_act = a; pre = p; post = q; snap = s; clr = c; rd_en = r;
        addr = AW'(ad);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, '0, 0, 0, 0, 0);
    endtask

    task automatic scan();
        for (int k = 0; k < NT; k++) step('0, '0, '0, 0, 0, 1, k);
        idle(1);
        // R4: after-veto never above before-veto, addresses per R8
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < 3; l++) begin
                int pa = NI + 6*c + 2*l;
                checks++;
                if (got[pa+1] > got[pa]) begin
                    errors++;
                    $display("FAIL R4 post=%0d expected <= pre=%0d", got[pa+1], got[pa]);
                end
            end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1"; scan();

        tag = "R2 R3 R8";
        for (int i = 0; i < 5; i++) step(3'b101, 6'b100101, 6'b000000, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(3'b010, 6'b011010, 6'b010010, 0, 0, 0, 0);
        step('0, '0, '0, 1, 0, 0, 0);
        scan();

        tag = "R4";
        for (int i = 0; i < 4; i++) step('0, 6'b000000, 6'b111111, 0, 0, 0, 0);
        for (int i = 0; i < 2; i++) step('0, 6'b110011, 6'b100001, 0, 0, 0, 0);
        step('0, '0, '0, 1, 0, 0, 0);
        scan();

        tag = "R6";
        for (int i = 0; i < 4; i++) step(3'b111, 6'b111111, 6'b111111, 0, 0, 0, 0);
        scan();
        step(3'b001, 6'b000001, '0, 1, 0, 0, 0);
        scan();

        tag = "R5";
        for (int i = 0; i < 70; i++) step(3'b001, 6'b000011, 6'b000011, 0, 0, 0, 0);
        step('0, '0, '0, 1, 0, 0, 0);
        scan();

        tag = "R7";
        step(3'b111, 6'b111111, 6'b111111, 1, 1, 0, 0);
        scan();
        step(3'b111, 6'b111111, 6'b111111, 0, 1, 0, 0);
        step('0, '0, '0, 1, 0, 0, 0);
        scan();

        tag = "R9";
        step('0, '0, '0, 0, 0, 1, 20);
        step('0, '0, '0, 0, 0, 1, 0);
        idle(4);
        step('0, '0, '0, 0, 0, 1, 31);
        step('0, '0, '0, 0, 0, 1, NT);
        idle(3);

        tag = "R2 R3 R4 R6 R7";
        for (int i = 0; i < 3000; i++)
            step(NI'($urandom), (3*NC)'($urandom), (3*NC)'($urandom),
                 ($urandom % 16) == 0, ($urandom % 200) == 0,
                 ($urandom % 2) == 0, int'($urandom % 20));
        step('0, '0, '0, 1, 0, 0, 0);
        scan();

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule